// File: doc/BRIEF.md
# Three-Level Wavelet Packet Decomposer

This block takes a stream of signed samples in frames of eight and runs a full three-level wavelet packet tree over each frame. Unlike a plain dyadic transform, it splits the high band again at every level as well as the low band. The first level pairs consecutive even and odd samples as they arrive and produces a low band and a high band of four samples each. At the second level, a snapshot register bank and a one-bit band select time-share a single low/high filter pair across both first-level bands. This yields four bands of two samples. At the third level, a second snapshot bank and a two-bit band select walk the four second-level bands through another filter pair. This yields eight single-sample bands.

The filter pair is a Haar pair: low = (a + b) >>> 1, high = (a − b) >>> 1, where a is the earlier sample. Because of the shift, every level keeps the input width without overflow. The eight final coefficients leave the block one per cycle, each with a three-bit band tag. A new frame can follow the previous one with no idle cycles, so the block sustains one input sample per clock.

Top module: `wpt_packet3`

## Requirements
- R1: The first level pairs the samples in order: sample 2k with sample 2k+1 of a frame, for k = 0 to 3. Each pair gives low = (a+b)>>>1 and high = (a−b)>>>1, where a is sample 2k, the sum and difference are taken at W+1 bits, and the shift is arithmetic.
- R2: The second and third levels split both the low and the high band of the level above, using the same pair operation. The coefficient tagged t equals the value a full packet-tree model gives for band t.
- R3: The band tag `out_band` gives the path through the tree, with 0 for low and 1 for high. Bit 2 is the level-1 choice, bit 1 the level-2 choice and bit 0 the level-3 choice. The eight coefficients of a frame appear on eight consecutive cycles with tags 0,1,…,7 in that order.
- R4: The coefficient tagged 0 is first visible 7 clock edges after the edge that captures the frame's eighth sample.
- R5: `done` is high for exactly one cycle, the cycle after the coefficient tagged 7, and at no other time.
- R6: Frames may arrive back to back, one sample every cycle, with no stall. Every frame is decomposed correctly.
- R7: A sample is taken only on a cycle with `in_valid` high. Idle cycles inside or between frames do not change pairing or results.
- R8: A synchronous active-high `rst` clears `out_valid` and `done` and discards a partly received frame. The next sample after reset is sample 0 of a new frame.
- R9: `out_valid` is low on every cycle that does not carry a frame coefficient.
- R10: Full-scale inputs (all maximum, all minimum, alternating extremes) give exact results with no wrap at width W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample on in_data is valid this cycle |
| in_data | input | W | Signed input sample |
| out_valid | output | 1 | out_data and out_band carry a coefficient |
| out_data | output | W | Signed third-level coefficient |
| out_band | output | 3 | Band tag: path bits, level 1 in the MSB |
| done | output | 1 | One-cycle pulse after a frame's last coefficient |

## Verification
On every cycle, the assertions check the emission pattern: a burst starts at tag 0, tags step by one, `done` follows tag 7 and appears nowhere else, and neither time-shared stage is restarted while it still holds a frame it has not finished. The coefficient values can only be shown by the bench scenarios. These compare each tagged output against a software packet-tree model over ramps, impulses, full-scale patterns and random frames, both back to back and with random idle gaps. The scenarios also cover the fixed seven-edge latency and the reset that drops a partial frame.

// File: rtl/wpt_pkg.sv
package wpt_pkg;
  localparam int WPT_LEVELS = 3;
  localparam int WPT_FRAME  = 1 << WPT_LEVELS;
  localparam int WPT_TAG_W  = WPT_LEVELS;

  typedef enum logic {
    BR_LOW  = 1'b0,
    BR_HIGH = 1'b1
  } branch_e;
endpackage

// File: rtl/wpt_haar_pair.sv
module wpt_haar_pair #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] lo,
  output logic signed [W-1:0] hi
);
  logic signed [W:0] sum_w;
  logic signed [W:0] dif_w;

  always_comb begin
    sum_w = {a[W-1], a} + {b[W-1], b};
    dif_w = {a[W-1], a} - {b[W-1], b};
    lo    = sum_w[W:1];
    hi    = dif_w[W:1];
  end
endmodule

// File: rtl/wpt_level1.sv
module wpt_level1 #(
  parameter int W     = 16,
  parameter int FRAME = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_data,
  output logic signed [W-1:0] bank [FRAME],
  output logic                full
);
  localparam int CW   = $clog2(FRAME);
  localparam int HALF = FRAME / 2;

  logic [CW-1:0]       cnt;
  logic signed [W-1:0] even_q;
  logic signed [W-1:0] f_lo, f_hi;
  logic [CW-2:0]       pidx;

  assign pidx = cnt[CW-1:1];

  wpt_haar_pair #(.W(W)) u_pair (
    .a (even_q),
    .b (in_data),
    .lo(f_lo),
    .hi(f_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      full <= 1'b0;
    end else begin
      full <= 1'b0;
      if (in_valid) begin
        cnt <= cnt + 1'b1;
        if (!cnt[0]) begin
          even_q <= in_data;
        end else begin
          bank[int'(pidx)]        <= f_lo;
          bank[HALF + int'(pidx)] <= f_hi;
          if (cnt == CW'(FRAME - 1)) full <= 1'b1;
        end
      end
    end
  end

  // R7: a completed frame is only ever flagged right after an accepted sample
  p_full_after_sample_r7: assert property (@(posedge clk) disable iff (rst)
    full |-> $past(in_valid));
  p_full_single_r7: assert property (@(posedge clk) disable iff (rst)
    full |=> !full);
endmodule

// File: rtl/wpt_band_stage.sv
module wpt_band_stage #(
  parameter int W        = 16,
  parameter int FRAME    = 8,
  parameter int IN_BANDS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic signed [W-1:0] src  [FRAME],
  output logic signed [W-1:0] bank [FRAME],
  output logic                full
);
  localparam int LEN   = FRAME / IN_BANDS;
  localparam int HALF  = LEN / 2;
  localparam int STEPS = FRAME / 2;
  localparam int SW    = $clog2(STEPS);
  localparam int PW    = $clog2(HALF);

  logic signed [W-1:0] snap [FRAME];
  logic                busy;
  logic [SW-1:0]       step;
  logic [SW-PW-1:0]    sel;
  logic [PW-1:0]       pidx;
  logic signed [W-1:0] op_a, op_b, f_lo, f_hi;
  int                  i_rd, i_lo, i_hi;

  assign sel  = step[SW-1:PW];
  assign pidx = step[PW-1:0];

  always_comb begin
    i_rd = int'(sel) * LEN + 2 * int'(pidx);
    i_lo = 2 * int'(sel) * HALF + int'(pidx);
    i_hi = i_lo + HALF;
    op_a = snap[i_rd];
    op_b = snap[i_rd + 1];
  end

  wpt_haar_pair #(.W(W)) u_pair (
    .a (op_a),
    .b (op_b),
    .lo(f_lo),
    .hi(f_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      step <= '0;
      full <= 1'b0;
    end else begin
      full <= 1'b0;
      if (start) begin
        snap <= src;
        busy <= 1'b1;
        step <= '0;
      end else if (busy) begin
        bank[i_lo] <= f_lo;
        bank[i_hi] <= f_hi;
        step       <= step + 1'b1;
        if (step == SW'(STEPS - 1)) begin
          busy <= 1'b0;
          full <= 1'b1;
        end
      end
    end
  end

  // R6: a new frame never lands in the snapshot while the previous one is still being split
  p_start_idle_r6: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
endmodule

// File: rtl/wpt_emit_stage.sv
module wpt_emit_stage
  import wpt_pkg::*;
#(
  parameter int W     = 16,
  parameter int FRAME = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic signed [W-1:0]  src [FRAME],
  output logic                 out_valid,
  output logic signed [W-1:0]  out_data,
  output logic [$clog2(FRAME)-1:0] out_band,
  output logic                 done
);
  localparam int TW = $clog2(FRAME);
  localparam logic [TW-1:0] LAST = TW'(FRAME - 1);

  logic signed [W-1:0] snap [FRAME];
  logic                busy;
  logic                last_q;
  logic [TW-1:0]       step;
  logic [TW-2:0]       sel;
  logic signed [W-1:0] op_a, op_b, f_lo, f_hi;

  assign sel = step[TW-1:1];

  always_comb begin
    op_a = snap[2 * int'(sel)];
    op_b = snap[2 * int'(sel) + 1];
  end

  wpt_haar_pair #(.W(W)) u_pair (
    .a (op_a),
    .b (op_b),
    .lo(f_lo),
    .hi(f_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      step      <= '0;
      last_q    <= 1'b0;
      done      <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_band  <= '0;
    end else begin
      out_valid <= busy;
      last_q    <= busy && (step == LAST);
      done      <= last_q;
      if (busy) begin
        out_data <= (step[0] == BR_LOW) ? f_lo : f_hi;
        out_band <= step;
        step     <= step + 1'b1;
        if (step == LAST) busy <= 1'b0;
      end
      if (start) begin
        snap <= src;
        busy <= 1'b1;
        step <= '0;
      end
    end
  end

  // R6: reload only when idle or on the final emission step
  p_start_ok_r6: assert property (@(posedge clk) disable iff (rst)
    start |-> (!busy || step == LAST));
  // R3: each burst opens at tag 0
  p_first_tag_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> out_band == '0);
  // R3: tags rise by one inside a burst
  p_tag_step_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_band != LAST) |=> (out_valid && out_band == $past(out_band) + 1'b1));
  // R5: the pulse follows the last tag
  p_done_follows_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_band == LAST) |=> done);
  // R5: no pulse anywhere else
  p_done_only_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(out_valid) && $past(out_band) == LAST));
endmodule

// File: rtl/wpt_packet3.sv
module wpt_packet3
  import wpt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [W-1:0]  in_data,
  output logic                 out_valid,
  output logic signed [W-1:0]  out_data,
  output logic [WPT_TAG_W-1:0] out_band,
  output logic                 done
);
  logic signed [W-1:0] l1_bank [WPT_FRAME];
  logic signed [W-1:0] l2_bank [WPT_FRAME];
  logic                l1_full, l2_full;

  wpt_level1 #(.W(W), .FRAME(WPT_FRAME)) u_lvl1 (
    .clk     (clk),
    .rst     (rst),
    .in_valid(in_valid),
    .in_data (in_data),
    .bank    (l1_bank),
    .full    (l1_full)
  );

  wpt_band_stage #(.W(W), .FRAME(WPT_FRAME), .IN_BANDS(2)) u_lvl2 (
    .clk  (clk),
    .rst  (rst),
    .start(l1_full),
    .src  (l1_bank),
    .bank (l2_bank),
    .full (l2_full)
  );

  wpt_emit_stage #(.W(W), .FRAME(WPT_FRAME)) u_lvl3 (
    .clk      (clk),
    .rst      (rst),
    .start    (l2_full),
    .src      (l2_bank),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_band (out_band),
    .done     (done)
  );

  // R9: the outputs stay idle while reset is held
  p_idle_in_reset_r9: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !done));
endmodule

// File: tb/wpt_packet3_tb.sv
module wpt_packet3_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W     = 16;
  localparam int FRAME = 8;

  typedef int frame_t [FRAME];

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                in_valid = 1'b0;
  logic signed [W-1:0] in_data = '0;
  logic                out_valid;
  logic signed [W-1:0] out_data;
  logic [2:0]          out_band;
  logic                done;

  wpt_packet3 #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_band(out_band), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  int    q_data [$];
  int    q_band [$];
  string q_req  [$];
  int    q_first [$];
  int    q_done  [$];

  function automatic void check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endfunction

  function automatic void model(input frame_t x, output frame_t y);
    frame_t v, n;
    v = x;
    n = x;
    for (int lev = 0; lev < 3; lev++) begin
      int len, half, nb;
      len  = FRAME >> lev;
      half = len / 2;
      nb   = 1 << lev;
      for (int b = 0; b < nb; b++) begin
        for (int p = 0; p < half; p++) begin
          int a, c;
          a = v[b*len + 2*p];
          c = v[b*len + 2*p + 1];
          n[2*b*half + p]     = (a + c) >>> 1;
          n[(2*b+1)*half + p] = (a - c) >>> 1;
        end
      end
      v = n;
    end
    y = v;
  endfunction

  task automatic send_frame(input frame_t x, input int gap_pct, input string req);
    frame_t y;
    model(x, y);
    for (int i = 0; i < FRAME; i++) begin
      while (gap_pct > 0 && int'($urandom % 100) < gap_pct) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = W'($urandom);
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = W'(x[i]);
      if (i == FRAME - 1) begin
        for (int t = 0; t < FRAME; t++) begin
          q_data.push_back(y[t]);
          q_band.push_back(t);
          q_req.push_back(req);
        end
        q_first.push_back(cyc + 1 + 7);
        q_done.push_back(cyc + 1 + 15);
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  function automatic frame_t rand_frame();
    frame_t f;
    for (int i = 0; i < FRAME; i++) f[i] = int'($urandom_range(0, 65535)) - 32768;
    return f;
  endfunction

  // output monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (q_data.size() == 0) begin
          check(1'b0, "R9", "out_valid with no coefficient due", 1, 0);
        end else begin
          int ed, eb;
          string er;
          ed = q_data.pop_front();
          eb = q_band.pop_front();
          er = q_req.pop_front();
          check(int'(out_band) == eb, "R3", "band tag order", int'(out_band), eb);
          check(int'(out_data) == ed, er, "coefficient value", int'(out_data), ed);
          if (eb == 0 && q_first.size() > 0) begin
            int ef;
            ef = q_first.pop_front();
            check(cyc == ef, "R4", "first coefficient edge", cyc, ef);
          end
        end
      end
      begin
        bit exp_done;
        exp_done = (q_done.size() > 0) && (q_done[0] == cyc);
        if (exp_done) void'(q_done.pop_front());
        if (exp_done || done) check(done == exp_done, "R5", "done pulse", int'(done), int'(exp_done));
      end
    end
  end

  bit finished = 1'b0;

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL R6 watchdog expired: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    frame_t f;
    int seed;
    seed = int'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8", "out_valid in reset", int'(out_valid), 0);
    check(done == 1'b0, "R8", "done in reset", int'(done), 0);
    rst = 1'b0;
    idle(2);

    // R1: ramp
    for (int i = 0; i < FRAME; i++) f[i] = i + 1;
    send_frame(f, 0, "R1");
    idle(20);
    check(out_valid == 1'b0, "R9", "idle after frame", int'(out_valid), 0);

    // R2: impulse at odd slot
    for (int i = 0; i < FRAME; i++) f[i] = (i == 5) ? 1000 : 0;
    send_frame(f, 0, "R2");
    idle(20);

    // R10: full scale patterns
    for (int i = 0; i < FRAME; i++) f[i] = 32767;
    send_frame(f, 0, "R10");
    for (int i = 0; i < FRAME; i++) f[i] = -32768;
    send_frame(f, 0, "R10");
    for (int i = 0; i < FRAME; i++) f[i] = (i % 2 == 0) ? 32767 : -32768;
    send_frame(f, 0, "R10");
    for (int i = 0; i < FRAME; i++) f[i] = (i < 4) ? -32768 : 32767;
    send_frame(f, 0, "R10");
    idle(20);

    // R6: back to back random frames
    for (int k = 0; k < 6; k++) send_frame(rand_frame(), 0, "R6");
    idle(20);

    // R7: random idle gaps
    for (int k = 0; k < 6; k++) send_frame(rand_frame(), 40, "R7");
    idle(25);
    check(out_valid == 1'b0, "R9", "idle after gapped frames", int'(out_valid), 0);

    // R8: partial frame dropped by reset
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = W'(777 * (i + 1));
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0 && done == 1'b0, "R8", "outputs during reset",
          int'(out_valid) + int'(done), 0);
    rst = 1'b0;
    for (int i = 0; i < FRAME; i++) f[i] = 100 * i - 300;
    send_frame(f, 0, "R8");
    idle(25);

    check(q_data.size() == 0, "R2", "coefficients left unseen", q_data.size(), 0);
    check(q_done.size() == 0, "R5", "done pulses left unseen", q_done.size(), 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule